// File: doc/BRIEF.md
# Video Timing Checker

This block decides whether an incoming digital video stream has the timing of the one supported resolution: 1024 by 768 at 60 Hz. It takes the raw horizontal and vertical sync lines from the pixel-clock side and brings them into a fixed reference clock domain. There it counts reference cycles between active sync edges. Each measured line period and frame period is compared against a nominal value with a tolerance window taken from an input port. The block raises a video-valid level only after several consecutive frames have matched. It drops that level at once when a line or frame falls outside its window, or when a sync line stops toggling.

On every active vertical sync edge the block also emits a one-cycle frame-start pulse in the reference domain. A downstream packet generator can lock its output frames to the source refresh rate with it.

The nominal line period is a parameter in reference cycles (1099 by default, which is about 20.68 us at 53.125 MHz). The frame period is derived as that value times the line count per frame (806 by default). Sync inputs are active high; their rising edge is the active edge.

Top module: `vtc_top`

## Requirements
- R1: While rst_n is low, and after it is released until the qualification in R5 completes, video_valid_o is 0. frame_start_o is 0 while rst_n is low.
- R2: Each rising edge of vsync_i yields exactly one frame_start_o pulse, one cycle wide. It is high in the second clock cycle after the first clock edge that samples vsync_i high.
- R3: A line period is the count of clock cycles between two consecutive rising edges of hsync_i. It is accepted when it lies in H_NOM plus or minus h_tol_i, bounds included.
- R4: A frame period is the count of clock cycles between two consecutive rising edges of vsync_i. It is accepted when it lies in H_NOM*FRAME_LINES plus or minus v_tol_i, bounds included.
- R5: A frame qualifies when its start edge was measured, its frame period is accepted and every line period measured inside it is accepted. video_valid_o rises after MATCH_FRAMES (3) consecutive qualifying frames, counted at their closing vsync edges. It stays high while frames keep qualifying.
- R6: A rejected line period clears video_valid_o and the qualification count within two cycles of that hsync edge, without waiting for the frame to end.
- R7: A rejected frame period clears video_valid_o and the qualification count at that vsync edge, even when every line was accepted.
- R8: If no hsync_i rising edge arrives within 2*H_NOM cycles of the previous one, video_valid_o drops and the horizontal measurement is disarmed.
- R9: If no vsync_i rising edge arrives within 2*H_NOM*FRAME_LINES cycles of the previous one, video_valid_o drops and the vertical measurement is disarmed.
- R10: The first edge on a sync line after reset or after its timeout is not measured and causes no fault. Qualification then needs MATCH_FRAMES more qualifying frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously |
| hsync_i | input | 1 | Horizontal sync from the pixel domain, active high |
| vsync_i | input | 1 | Vertical sync from the pixel domain, active high |
| h_tol_i | input | TOL_W | Line period tolerance in reference cycles |
| v_tol_i | input | TOL_W | Frame period tolerance in reference cycles |
| frame_start_o | output | 1 | One-cycle pulse per vertical sync edge |
| video_valid_o | output | 1 | Timing matches the supported resolution |

## Verification
Most internal faults show at video_valid_o, one or more whole frames late or early. A counter that starts one off, or a meter armed too early after reset, delays or advances the rise by a frame. That is seen at the check placed a few cycles after each frame start. Window bound errors show within two cycles of the measuring hsync edge, because lines set exactly on the tolerance bound and one cycle past it are driven. A lost or doubled frame-start pulse is seen at the exact cycle the pulse is expected and the one after.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  // one measurement result, registered by a period meter
  typedef struct packed {
    logic done;   // active edge seen this cycle
    logic armed;  // a previous edge existed, period is meaningful
    logic ok;     // period inside window
    logic tmo;    // no edge within twice the nominal period
  } meas_t;
endpackage

// File: rtl/vtc_sync_edge.sv
module vtc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/vtc_period_meter.sv
module vtc_period_meter
  import vtc_pkg::*;
#(
  parameter int NOM   = 1099,
  parameter int TOL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic [TOL_W-1:0] tol_i,
  output meas_t            meas_o
);
  localparam int LIMIT = 2 * NOM;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  meas_t         meas_q, meas_d;
  logic [31:0]   cnt_w, tol_w;
  logic          in_win, at_limit;

  assign cnt_w    = 32'(cnt_q);
  assign tol_w    = 32'(tol_i);
  assign in_win   = (cnt_w + tol_w >= 32'(NOM)) && (cnt_w <= 32'(NOM) + tol_w);
  assign at_limit = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    meas_d  = '0;
    if (edge_i) begin
      meas_d.done  = 1'b1;
      meas_d.armed = armed_q;
      meas_d.ok    = armed_q & in_win;
      cnt_d        = CW'(1);
      armed_d      = 1'b1;
    end else if (armed_q) begin
      if (at_limit) begin
        armed_d     = 1'b0;
        meas_d.tmo  = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      meas_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      meas_q  <= meas_d;
    end
  end

  assign meas_o = meas_q;

  assert_timeout_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !edge_i && at_limit) |=> (meas_q.tmo && !armed_q));
  assert_first_edge_unmeasured_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !armed_q) |=> (meas_q.done && !meas_q.ok));
endmodule

// File: rtl/vtc_qualifier.sv
module vtc_qualifier
  import vtc_pkg::*;
#(
  parameter int MATCH = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  meas_t h_m,
  input  meas_t v_m,
  output logic  valid_o
);
  localparam int GW = $clog2(MATCH + 1);

  logic [GW-1:0] good_q, good_d;
  logic          valid_q, valid_d;
  logic          line_bad_q, line_bad_d;
  logic          h_fault, any_tmo;

  assign h_fault = h_m.done & h_m.armed & ~h_m.ok;
  assign any_tmo = h_m.tmo | v_m.tmo;

  always_comb begin
    good_d     = good_q;
    valid_d    = valid_q;
    line_bad_d = line_bad_q;
    if (h_fault || any_tmo) begin
      good_d     = '0;
      valid_d    = 1'b0;
      line_bad_d = 1'b1;
    end
    if (v_m.done) begin
      line_bad_d = 1'b0;
      if (v_m.armed && v_m.ok && !line_bad_q && !h_fault && !any_tmo) begin
        good_d  = (good_q == GW'(MATCH)) ? good_q : good_q + GW'(1);
        valid_d = (good_d == GW'(MATCH));
      end else begin
        good_d  = '0;
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q     <= '0;
      valid_q    <= 1'b0;
      line_bad_q <= 1'b0;
    end else begin
      good_q     <= good_d;
      valid_q    <= valid_d;
      line_bad_q <= line_bad_d;
    end
  end

  assign valid_o = valid_q;

  assert_rise_on_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(v_m.done && v_m.ok));
  assert_line_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_m.done && h_m.armed && !h_m.ok) |=> !valid_q);
  assert_frame_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_m.done && v_m.armed && !v_m.ok) |=> !valid_q);
  assert_timeout_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_m.tmo || v_m.tmo) |=> !valid_q);
endmodule

// File: rtl/vtc_top.sv
module vtc_top
  import vtc_pkg::*;
#(
  parameter int H_NOM        = 1099,
  parameter int FRAME_LINES  = 806,
  parameter int MATCH_FRAMES = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int TOL_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic [TOL_W-1:0] h_tol_i,
  input  logic [TOL_W-1:0] v_tol_i,
  output logic             frame_start_o,
  output logic             video_valid_o
);
  localparam int V_NOM = H_NOM * FRAME_LINES;

  logic [1:0] sync_raw, sync_rise;
  meas_t      h_meas, v_meas;

  assign sync_raw = {vsync_i, hsync_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    vtc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sync_raw[g]),
      .rise_o  (sync_rise[g])
    );
  end

  vtc_period_meter #(.NOM(H_NOM), .TOL_W(TOL_W)) u_hmeter (
    .clk    (clk),
    .rst_n  (rst_n),
    .edge_i (sync_rise[0]),
    .tol_i  (h_tol_i),
    .meas_o (h_meas)
  );

  vtc_period_meter #(.NOM(V_NOM), .TOL_W(TOL_W)) u_vmeter (
    .clk    (clk),
    .rst_n  (rst_n),
    .edge_i (sync_rise[1]),
    .tol_i  (v_tol_i),
    .meas_o (v_meas)
  );

  vtc_qualifier #(.MATCH(MATCH_FRAMES)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_m     (h_meas),
    .v_m     (v_meas),
    .valid_o (video_valid_o)
  );

  assign frame_start_o = sync_rise[1];
endmodule

// File: tb/vtc_top_tb_top.sv
module vtc_top_tb_top;
  localparam int HN = 40;
  localparam int LN = 4;
  localparam int VN = HN * LN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync = 1'b0;
  logic        vsync = 1'b0;
  logic [15:0] h_tol_p, v_tol_p;
  logic        fs, vv;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int h_tol = 2;
  int v_tol = 8;
  int good = 0;
  bit v_armed = 0;
  int prev_l = 0;

  typedef struct {
    bit    is_fs;
    bit    exp;
    string req;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  assign h_tol_p = 16'(h_tol);
  assign v_tol_p = 16'(v_tol);

  vtc_top #(.H_NOM(HN), .FRAME_LINES(LN), .MATCH_FRAMES(3)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hsync_i       (hsync),
    .vsync_i       (vsync),
    .h_tol_i       (h_tol_p),
    .v_tol_i       (v_tol_p),
    .frame_start_o (fs),
    .video_valid_o (vv)
  );

  function automatic bit h_win(int l);
    return (l >= HN - h_tol) && (l <= HN + h_tol);
  endfunction

  function automatic bit v_win(int p);
    return (p >= VN - v_tol) && (p <= VN + v_tol);
  endfunction

  task automatic push(bit is_fs, bit exp, string req);
    item_t it;
    it.is_fs = is_fs;
    it.exp   = exp;
    it.req   = req;
    q.push_back(it);
  endtask

  // monitor: samples one time step after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        bit act;
        it  = q.pop_front();
        act = it.is_fs ? fs : vv;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s %s actual=%0b expected=%0b t=%0t", it.req,
                   it.is_fs ? "frame_start" : "valid", act, it.exp, $time);
        end
      end
    end
  end

  task automatic drive_line(int l, bit vs, bit chk, bit expv, string req);
    for (int k = 0; k < l; k++) begin
      @(negedge clk);
      hsync = (k < 4);
      vsync = vs;
      if (vs && k == 1) push(1'b1, 1'b1, "R2");
      if (vs && k == 2) push(1'b1, 1'b0, "R2");
      if (chk && k == 8) push(1'b0, expv, req);
    end
  endtask

  task automatic send_frame(int l, string req);
    bit expv;
    if (v_armed && h_win(prev_l) && v_win(prev_l * LN)) begin
      if (good < 3) good++;
    end else begin
      good = 0;
    end
    expv = (good >= 3);
    drive_line(l, 1'b1, 1'b1, expv, req);
    if (!h_win(l)) begin
      good = 0;
      expv = 1'b0;
    end
    drive_line(l, 1'b0, 1'b1, expv, req);
    for (int n = 2; n < LN; n++) drive_line(l, 1'b0, 1'b0, 1'b0, req);
    v_armed = 1'b1;
    prev_l  = l;
  endtask

  // both syncs stop: horizontal timeout first, vertical later
  task automatic quiet_gap(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hsync = 1'b0;
      vsync = 1'b0;
      if (k == 60) push(1'b0, 1'b0, "R8");
    end
    good = 0; v_armed = 1'b0; prev_l = 0;
  endtask

  // lines keep coming, vertical sync stops
  task automatic lines_only(int n);
    for (int k = 0; k < n; k++) drive_line(HN, 1'b0, 1'b0, 1'b0, "R9");
    @(negedge clk);
    push(1'b0, 1'b0, "R9");
    good = 0; v_armed = 1'b0; prev_l = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    push(1'b0, 1'b0, "R1");
    push(1'b1, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    // R5/R10: valid only at the fourth frame start after reset
    for (int f = 0; f < 5; f++) send_frame(HN, "R5/R10");
    // R3/R4: lines and frames exactly on the window bounds are accepted
    send_frame(HN + 2, "R3/R4");
    send_frame(HN - 2, "R3/R4");
    send_frame(HN, "R3/R4");
    // R6: one cycle beyond the line window
    send_frame(HN + 3, "R6");
    for (int f = 0; f < 5; f++) send_frame(HN, "R5");
    // R7: lines accepted, frame period outside a tighter window
    v_tol = 4;
    send_frame(HN + 2, "R7");
    send_frame(HN, "R7");
    v_tol = 8;
    for (int f = 0; f < 4; f++) send_frame(HN, "R5");
    // R8 then R10: recovery after both timeouts
    quiet_gap(400);
    for (int f = 0; f < 5; f++) send_frame(HN, "R10");
    // R9: vertical timeout with lines still arriving
    lines_only(12);
    for (int f = 0; f < 5; f++) send_frame(HN, "R10");
    // R1: reset while valid
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    push(1'b0, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    good = 0; v_armed = 1'b0; prev_l = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule